// File: doc/BRIEF.md
# Descriptor-Ring Memory Copy Channel

This block is one memory-to-memory copy channel. It takes its work from a ring of 16-byte buffer descriptors held in the same memory that it copies. A start command gives it the ring base address. The channel then fetches each descriptor as four 32-bit words. If the descriptor is valid, the channel copies the described number of words from the source pointer to the destination pointer. It then closes the descriptor and moves on, either to the next 16-byte slot or back to the ring base. All memory traffic uses one word-wide request/acknowledge port: the channel holds a request until the memory acknowledges it, and read data arrives with the acknowledge.

Four sticky event flags report how the channel stopped or what it finished: stop completed, ran out of buffers, terminated by an external DONE, and descriptor completed. A mask register with the same layout gates these flags onto one interrupt line. Software clears an event by writing 1 to its bit.

The sequencer has seven states. IDLE waits for start and answers a stop at once. FETCH reads the four descriptor words. DECODE checks the valid bit and the word count. READ loads one source word. WRITE stores that word at the destination. CLOSE writes back control word 0 with the valid bit cleared, or skips the write-back in continuous mode. ADVANCE posts completion events and picks the next descriptor.

The transitions are:
- IDLE→FETCH on start.
- FETCH→DECODE after the fourth word.
- DECODE→IDLE when the descriptor is invalid or a stop is pending.
- DECODE→CLOSE when the word count is zero.
- DECODE→READ otherwise.
- READ→WRITE on acknowledge.
- WRITE→READ while words remain.
- WRITE→CLOSE after the last word, or after an external DONE.
- WRITE→IDLE on a pending stop.
- CLOSE→ADVANCE.
- ADVANCE→IDLE after an external DONE, after a last descriptor, or on a pending stop.
- ADVANCE→FETCH otherwise.

Top module: `dmaeng_channel`

## Requirements
- R1: The descriptor at address A is read as four words from A, A+4, A+8 and A+12, in that order. Word 0 holds the control halfword in bits 31:16, with valid at bit 31, wrap at bit 29, interrupt at bit 28, last at bit 27 and continuous at bit 25. Word 1 is the byte count, and its two low bits are ignored, so the channel copies count/4 words. Word 2 is the source pointer and word 3 is the destination pointer.
- R2: Data words are copied in ascending address order. Each word is one read of the source followed by one write of the same value to the destination. Nothing beyond count/4 words is written, and a count below 4 copies nothing.
- R3: When a descriptor finishes, word 0 is written back with bit 31 cleared and every other bit unchanged. If the continuous bit is set, no write-back is made.
- R4: The next descriptor is at the current address plus 16, or at the ring base when the wrap bit is set.
- R5: A descriptor with the last bit set returns the channel to idle after it completes, and the out-of-buffers event stays clear.
- R6: A fetched descriptor with bit 31 clear sets the out-of-buffers event and returns the channel to idle. No data read or write follows it.
- R7: The descriptor-completed event is set after the final data write, and only for descriptors whose interrupt bit is set.
- R8: If ext_done is high while data is moving, the word in flight is still written. The descriptor is then closed as in R3, the external-DONE event is set, the channel goes idle, and descriptor-completed is not set.
- R9: A stop in idle sets stop-completed on the next clock edge. A stop while running halts the channel after the current memory word: the descriptor is not closed, and stop-completed is set as the channel enters idle.
- R10: The event register reads as 8 bits, with bits 7:4 always zero. Bit 3 is stop-completed, bit 2 is out-of-buffers, bit 1 is external-DONE and bit 0 is descriptor-completed. Each bit stays set until a write with a 1 in that position clears it. Writes to bits 7:4 do nothing.
- R11: The mask register uses the same layout, and its bits 7:4 read as zero. irq is high exactly when some event bit and its matching mask bit are both set.
- R12: A start is taken only in idle. A start while running does not change the ring that is being walked.
- R13: A memory request keeps its address, direction and write data unchanged until mem_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start pulse, loads the ring base |
| cmd_base | input | AW | Ring base byte address |
| cmd_stop | input | 1 | Stop request pulse |
| ext_done | input | 1 | External terminate request |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| evt_wr | input | 1 | Write-one-to-clear strobe for events |
| msk_wr | input | 1 | Mask register write strobe |
| reg_wdata | input | 8 | Data for event and mask writes |
| evt_q | output | 8 | Event register |
| mask_q | output | 8 | Mask register |
| irq | output | 1 | Masked event interrupt |

## Verification
If the sequencer is in the wrong state, the memory port shows it within one access. Examples are extra descriptor reads, a data write that is missing or misplaced, a write-back to the wrong slot, or no requests at all. The bench therefore counts every read and write and compares destination memory word by word against values computed from the descriptors. Errors in the event, mask or interrupt logic appear on evt_q and irq one clock after the causing memory acknowledge or command. The bench compares those outputs after each scenario settles.

// File: rtl/dmaeng_pkg.sv
package dmaeng_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_READ,
        ST_WRITE,
        ST_CLOSE,
        ST_ADVANCE
    } dma_state_e;

    // control word 0 bit positions (bit 31 = first bit of the halfword)
    localparam int CTL_VALID = 31;
    localparam int CTL_WRAP  = 29;
    localparam int CTL_INTR  = 28;
    localparam int CTL_LAST  = 27;
    localparam int CTL_CONT  = 25;

    // event bit positions
    localparam int EV_STOP  = 3;
    localparam int EV_NOBUF = 2;
    localparam int EV_XDONE = 1;
    localparam int EV_DESC  = 0;

    localparam int DESC_BYTES = 16;
    localparam int WORD_BYTES = 4;
endpackage

// File: rtl/dmaeng_evt.sv
module dmaeng_evt #(
    parameter int NEV = 4,
    parameter int RW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NEV-1:0] ev_set,
    input  logic          evt_wr,
    input  logic          msk_wr,
    input  logic [RW-1:0] reg_wdata,
    output logic [RW-1:0] evt_q,
    output logic [RW-1:0] mask_q,
    output logic          irq
);
    localparam int PAD = RW - NEV;

    logic [NEV-1:0] ev_r;
    logic [NEV-1:0] mk_r;

    for (genvar i = 0; i < NEV; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ev_r[i] <= 1'b0;
                mk_r[i] <= 1'b0;
            end else begin
                // a new event wins over a clear in the same cycle
                if (ev_set[i])
                    ev_r[i] <= 1'b1;
                else if (evt_wr && reg_wdata[i])
                    ev_r[i] <= 1'b0;
                if (msk_wr)
                    mk_r[i] <= reg_wdata[i];
            end
        end

        assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_r[i] && !(evt_wr && reg_wdata[i])) |=> ev_r[i]);
    end

    assign evt_q  = {{PAD{1'b0}}, ev_r};
    assign mask_q = {{PAD{1'b0}}, mk_r};
    assign irq    = |(ev_r & mk_r);
endmodule

// File: rtl/dmaeng_seq.sv
module dmaeng_seq
    import dmaeng_pkg::*;
#(
    parameter int AW = 32,
    parameter int LW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_start,
    input  logic [AW-1:0] cmd_base,
    input  logic          cmd_stop,
    input  logic          ext_done,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic [3:0]    ev_set
);
    localparam int WCW = LW - 2;

    dma_state_e    state_q, state_d;
    logic [AW-1:0] base_q, cur_q, src_q, dst_q;
    logic [31:0]   ctl_q, data_q;
    logic [WCW-1:0] wcnt_q;
    logic [1:0]    widx_q;
    logic          stop_pend_q, xdone_q;
    logic          stop_now, xd_now, to_idle;

    assign stop_now = stop_pend_q | cmd_stop;
    assign xd_now   = xdone_q | ext_done;

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:
                if (cmd_start && !cmd_stop) state_d = ST_FETCH;
            ST_FETCH:
                if (mem_ack && widx_q == 2'd3) state_d = ST_DECODE;
            ST_DECODE:
                if (!ctl_q[CTL_VALID] || stop_now) state_d = ST_IDLE;
                else if (wcnt_q == '0)             state_d = ST_CLOSE;
                else                               state_d = ST_READ;
            ST_READ:
                if (mem_ack) state_d = ST_WRITE;
            ST_WRITE:
                if (mem_ack) begin
                    if (xd_now)                state_d = ST_CLOSE;
                    else if (stop_now)         state_d = ST_IDLE;
                    else if (wcnt_q == WCW'(1)) state_d = ST_CLOSE;
                    else                       state_d = ST_READ;
                end
            ST_CLOSE:
                if (ctl_q[CTL_CONT] || mem_ack) state_d = ST_ADVANCE;
            ST_ADVANCE:
                if (xdone_q || ctl_q[CTL_LAST] || stop_now) state_d = ST_IDLE;
                else                                         state_d = ST_FETCH;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign to_idle = (state_q != ST_IDLE) && (state_d == ST_IDLE);

    // output process: memory port and event pulses
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        ev_set    = '0;
        unique case (state_q)
            ST_IDLE: begin
                ev_set[EV_STOP] = cmd_stop;
            end
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = cur_q + AW'({widx_q, 2'b00});
            end
            ST_DECODE: begin
                ev_set[EV_NOBUF] = !ctl_q[CTL_VALID];
            end
            ST_READ: begin
                mem_req  = 1'b1;
                mem_addr = src_q;
            end
            ST_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_q;
                mem_wdata = data_q;
            end
            ST_CLOSE: begin
                mem_req   = !ctl_q[CTL_CONT];
                mem_we    = 1'b1;
                mem_addr  = cur_q;
                mem_wdata = ctl_q & ~(32'd1 << CTL_VALID);
            end
            ST_ADVANCE: begin
                ev_set[EV_DESC]  = ctl_q[CTL_INTR] && !xdone_q;
                ev_set[EV_XDONE] = xdone_q;
            end
            default: ;
        endcase
        if (to_idle && stop_now)
            ev_set[EV_STOP] = 1'b1;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q      <= '0;
            cur_q       <= '0;
            src_q       <= '0;
            dst_q       <= '0;
            ctl_q       <= '0;
            data_q      <= '0;
            wcnt_q      <= '0;
            widx_q      <= '0;
            stop_pend_q <= 1'b0;
            xdone_q     <= 1'b0;
        end else begin
            if (state_q != ST_IDLE && cmd_stop)
                stop_pend_q <= 1'b1;
            if (to_idle)
                stop_pend_q <= 1'b0;
            if ((state_q == ST_READ || state_q == ST_WRITE) && ext_done)
                xdone_q <= 1'b1;
            unique case (state_q)
                ST_IDLE:
                    if (cmd_start && !cmd_stop) begin
                        base_q  <= cmd_base;
                        cur_q   <= cmd_base;
                        widx_q  <= '0;
                        xdone_q <= 1'b0;
                    end
                ST_FETCH:
                    if (mem_ack) begin
                        unique case (widx_q)
                            2'd0: ctl_q  <= mem_rdata;
                            2'd1: wcnt_q <= mem_rdata[LW-1:2];
                            2'd2: src_q  <= mem_rdata[AW-1:0];
                            2'd3: dst_q  <= mem_rdata[AW-1:0];
                            default: ;
                        endcase
                        widx_q <= widx_q + 2'd1;
                    end
                ST_READ:
                    if (mem_ack) data_q <= mem_rdata;
                ST_WRITE:
                    if (mem_ack) begin
                        src_q  <= src_q + AW'(WORD_BYTES);
                        dst_q  <= dst_q + AW'(WORD_BYTES);
                        wcnt_q <= wcnt_q - WCW'(1);
                    end
                ST_ADVANCE:
                    if (state_d == ST_FETCH) begin
                        cur_q   <= ctl_q[CTL_WRAP] ? base_q : cur_q + AW'(DESC_BYTES);
                        widx_q  <= '0;
                        xdone_q <= 1'b0;
                    end
                default: ;
            endcase
        end
    end

    assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    assert_nobuf_halts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_set[EV_NOBUF] |=> (!mem_req && state_q == ST_IDLE));

    assert_wrap_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADVANCE && state_d == ST_FETCH && ctl_q[CTL_WRAP]) |=> (cur_q == base_q));

    assert_start_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && cmd_start) |=> $stable(base_q));

    assert_no_desc_on_xdone_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_set[EV_XDONE] |-> !ev_set[EV_DESC]);
endmodule

// File: rtl/dmaeng_channel.sv
module dmaeng_channel #(
    parameter int AW = 32,
    parameter int LW = 32,
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_start,
    input  logic [AW-1:0] cmd_base,
    input  logic          cmd_stop,
    input  logic          ext_done,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    input  logic          evt_wr,
    input  logic          msk_wr,
    input  logic [RW-1:0] reg_wdata,
    output logic [RW-1:0] evt_q,
    output logic [RW-1:0] mask_q,
    output logic          irq
);
    localparam int NEV = 4;

    logic [NEV-1:0] ev_set;

    dmaeng_seq #(.AW(AW), .LW(LW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_start(cmd_start),
        .cmd_base (cmd_base),
        .cmd_stop (cmd_stop),
        .ext_done (ext_done),
        .mem_req  (mem_req),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_ack  (mem_ack),
        .mem_rdata(mem_rdata),
        .ev_set   (ev_set)
    );

    dmaeng_evt #(.NEV(NEV), .RW(RW)) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_set   (ev_set),
        .evt_wr   (evt_wr),
        .msk_wr   (msk_wr),
        .reg_wdata(reg_wdata),
        .evt_q    (evt_q),
        .mask_q   (mask_q),
        .irq      (irq)
    );
endmodule

// File: tb/dmaeng_channel_test.sv
`timescale 1ns/1ps
module dmaeng_channel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0, cmd_stop = 1'b0, ext_done = 1'b0;
    logic [31:0] cmd_base = '0;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        evt_wr = 1'b0, msk_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  evt_q, mask_q;
    logic        irq;

    int checks = 0, fails = 0;
    int rd_cnt = 0, wr_cnt = 0, hold_err = 0;
    logic [31:0] mem [0:255];
    logic        prev_wait = 1'b0;
    logic [31:0] prev_addr = '0;

    localparam logic [31:0] SENT = 32'hDEAD_BEEF;

    always #5 clk = ~clk;

    dmaeng_channel uut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_base(cmd_base),
        .cmd_stop(cmd_stop), .ext_done(ext_done), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .evt_wr(evt_wr), .msk_wr(msk_wr), .reg_wdata(reg_wdata), .evt_q(evt_q),
        .mask_q(mask_q), .irq(irq)
    );

    // memory model: acknowledge one cycle after a request
    always @(posedge clk) begin
        mem_ack <= mem_req && !mem_ack;
        mem_rdata <= mem[mem_addr[9:2]];
        if (mem_req && !mem_ack) begin
            if (mem_we) begin
                mem[mem_addr[9:2]] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    // R13 monitor: a waiting request keeps its address
    always @(negedge clk) begin
        if (prev_wait && (!mem_req || mem_addr != prev_addr)) hold_err <= hold_err + 1;
        prev_wait <= mem_req && !mem_ack;
        prev_addr <= mem_addr;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = SENT;
        rd_cnt = 0;
        wr_cnt = 0;
    endtask

    task automatic put_desc(input int a, input logic [31:0] w0, input logic [31:0] len,
                            input logic [31:0] src, input logic [31:0] dst);
        mem[a/4] = w0; mem[a/4+1] = len; mem[a/4+2] = src; mem[a/4+3] = dst;
    endtask

    task automatic fill_src(input int a, input int n, input int seed);
        for (int i = 0; i < n; i++) mem[a/4+i] = 32'h0101_0101 * (i + 1) + seed;
    endtask

    task automatic pulse_start(input logic [31:0] base);
        @(negedge clk); cmd_base = base; cmd_start = 1'b1;
        @(negedge clk); cmd_start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); cmd_stop = 1'b1;
        @(negedge clk); cmd_stop = 1'b0;
    endtask

    task automatic wr_evt(input logic [7:0] d);
        @(negedge clk); evt_wr = 1'b1; reg_wdata = d;
        @(negedge clk); evt_wr = 1'b0;
    endtask

    task automatic wr_msk(input logic [7:0] d);
        @(negedge clk); msk_wr = 1'b1; reg_wdata = d;
        @(negedge clk); msk_wr = 1'b0;
    endtask

    task automatic wait_quiet();
        int q = 0;
        for (int i = 0; i < 5000 && q < 10; i++) begin
            @(negedge clk);
            q = mem_req ? 0 : q + 1;
        end
    endtask

    task automatic wait_writes(input int n);
        for (int i = 0; i < 5000 && wr_cnt < n; i++) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        clear_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R10 reset evt", {24'd0, evt_q}, 32'h0);
        chk("R11 reset mask", {24'd0, mask_q}, 32'h0);
        chk("R11 reset irq", {31'd0, irq}, 32'h0);
        chk("R13 reset req", {31'd0, mem_req}, 32'h0);

        // R9: stop in idle
        @(negedge clk); cmd_stop = 1'b1;
        @(negedge clk); cmd_stop = 1'b0;
        chk("R9 idle stop", {24'd0, evt_q}, 32'h08);
        wr_evt(8'hF0);
        chk("R10 reserved write ignored", {24'd0, evt_q}, 32'h08);
        wr_evt(8'h08);
        chk("R10 w1c", {24'd0, evt_q}, 32'h00);

        // R1 R3 R4 R7 R6: two-entry ring
        clear_mem();
        put_desc(32'h00, 32'h9000_1234, 32'd12, 32'h100, 32'h200);
        put_desc(32'h10, 32'hB200_0000, 32'd8, 32'h140, 32'h240);
        fill_src(32'h100, 3, 7);
        fill_src(32'h140, 2, 9);
        pulse_start(32'h0);
        wait_quiet();
        for (int i = 0; i < 3; i++) chk("R2 ring d0 data", mem[32'h200/4+i], 32'h0101_0101*(i+1)+7);
        for (int i = 0; i < 2; i++) chk("R4 ring d1 data", mem[32'h240/4+i], 32'h0101_0101*(i+1)+9);
        chk("R3 d0 valid cleared", mem[0], 32'h1000_1234);
        chk("R3 d1 continuous untouched", mem[4], 32'hB200_0000);
        chk("R7 R6 ring events", {24'd0, evt_q}, 32'h05);
        chk("R1 ring reads", rd_cnt, 17);
        chk("R2 ring writes", wr_cnt, 6);

        // R11 mask
        wr_msk(8'hFF);
        chk("R11 mask upper zero", {24'd0, mask_q}, 32'h0F);
        chk("R11 irq on", {31'd0, irq}, 32'h1);
        wr_msk(8'h02);
        chk("R11 irq masked", {31'd0, irq}, 32'h0);
        wr_msk(8'h04);
        chk("R11 irq nobuf", {31'd0, irq}, 32'h1);
        wr_evt(8'hFF);
        chk("R10 clear all", {24'd0, evt_q}, 32'h0);

        // R6: invalid descriptor only
        clear_mem();
        put_desc(32'h80, 32'h7FFF_FFFF, 32'd16, 32'h100, 32'h200);
        pulse_start(32'h80);
        wait_quiet();
        chk("R6 nobuf event", {24'd0, evt_q}, 32'h04);
        chk("R6 reads", rd_cnt, 4);
        chk("R6 writes", wr_cnt, 0);
        wr_evt(8'hFF);

        // R5 R2 R7 R1: sweep over word count and interrupt bit
        for (int n = 0; n < 7; n++) begin
            for (int in = 0; in < 2; in++) begin
                logic [31:0] w0;
                int good;
                clear_mem();
                w0 = 32'h8800_0000 | (in != 0 ? 32'h1000_0000 : 32'h0);
                put_desc(32'h80, w0, n*4 + (n % 4), 32'h100, 32'h200);
                fill_src(32'h100, 8, n);
                pulse_start(32'h80);
                wait_quiet();
                good = 1;
                for (int i = 0; i < n; i++)
                    if (mem[32'h200/4+i] !== 32'h0101_0101*(i+1)+n) good = 0;
                chk("R2 sweep data", good, 1);
                chk("R2 sweep no overrun", mem[32'h200/4+n], SENT);
                chk("R7 R5 sweep events", {24'd0, evt_q}, in != 0 ? 32'h01 : 32'h00);
                chk("R1 sweep reads", rd_cnt, 4 + n);
                chk("R3 sweep writes", wr_cnt, n + 1);
                chk("R3 sweep close", mem[32'h80/4], w0 & 32'h7FFF_FFFF);
                wr_evt(8'hFF);
            end
        end

        // R8: external terminate
        begin
            int k;
            int good;
            clear_mem();
            put_desc(32'h00, 32'h9000_0000, 32'd40, 32'h100, 32'h200);
            fill_src(32'h100, 10, 3);
            pulse_start(32'h0);
            wait_writes(3);
            @(negedge clk); ext_done = 1'b1;
            @(negedge clk); ext_done = 1'b0;
            wait_quiet();
            k = 0;
            while (k < 10 && mem[32'h200/4+k] !== SENT) k++;
            good = (k >= 3 && k < 10) ? 1 : 0;
            for (int i = 0; i < k; i++)
                if (mem[32'h200/4+i] !== 32'h0101_0101*(i+1)+3) good = 0;
            chk("R8 partial copy", good, 1);
            chk("R8 event", {24'd0, evt_q}, 32'h02);
            chk("R8 closed", mem[0], 32'h1000_0000);
            wr_evt(8'hFF);
        end

        // R9 R12: stop while running, start ignored
        begin
            int k;
            int good;
            clear_mem();
            put_desc(32'h00, 32'h9000_0000, 32'd40, 32'h100, 32'h200);
            put_desc(32'h40, 32'h9800_0000, 32'd8, 32'h100, 32'h300);
            fill_src(32'h100, 10, 5);
            pulse_start(32'h0);
            wait_writes(2);
            pulse_start(32'h40);
            wait_writes(4);
            pulse_stop();
            wait_quiet();
            k = 0;
            while (k < 10 && mem[32'h200/4+k] !== SENT) k++;
            good = (k >= 4 && k < 10) ? 1 : 0;
            for (int i = 0; i < k; i++)
                if (mem[32'h200/4+i] !== 32'h0101_0101*(i+1)+5) good = 0;
            chk("R9 partial copy", good, 1);
            chk("R9 stop event", {24'd0, evt_q}, 32'h08);
            chk("R9 not closed", mem[0], 32'h9000_0000);
            chk("R12 other ring untouched", mem[32'h300/4], SENT);
            chk("R12 other desc untouched", mem[32'h40/4], 32'h9800_0000);
        end

        chk("R13 request hold", hold_err, 0);
        summary();
    end
endmodule